// File: doc/BRIEF.md
# Register-File Serial Slave (I2C)

This block is an I2C slave with a 7-bit address. It gives a serial master access to a small bank of 8-bit registers. Part of the bank is control registers, which are held in the block and presented on a flat output bus. The rest is status registers, which are read live from a flat input bus. SCL and SDA reach the block as plain inputs that are oversampled in the system clock domain. The block returns a single open-drain enable: when it is high, the pad pulls SDA low.

A transfer opens with a START and an address byte. The next byte loads an internal register pointer, and any bytes after it are written at that pointer. To read, the master issues a repeated START and readdresses the slave with the read bit set. The slave then streams bytes from the pointer until the master answers with a NACK. The pointer advances after every data byte in either direction. It survives STOP, so a read that skips the pointer byte continues from where the last transfer stopped. The two low bits of the slave address come from a strap input, so four copies can share one bus.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe` low), every control register reads 00h and no write strobe is active.
- R2: The slave answers to the 7-bit address {BASE_ADDR[6:2], addr_sel[1:0]}. The first byte after a START or repeated START carries that address in its upper seven bits and the read flag in bit 0 (1 means read). On a match the slave ACKs.
- R3: An address byte that does not match is NACKed. The slave then leaves SDA released for every later bit, until the next START.
- R4: The slave ACKs by pulling SDA low for the entire ninth clock after a matching address byte, after the pointer byte and after each written byte. A written byte lands in the control register that the pointer selects.
- R5: The 8-bit pointer increments after each written byte and after each read byte, and wraps from FFh to 00h.
- R6: After a repeated START with the read flag set, the slave sends the byte at the pointer, MSB first, and changes SDA only while SCL is low. Control register k sits at address k (0 to NUM_CTRL-1). Status register j sits at address NUM_CTRL+j.
- R7: The pointer is kept across STOP. A read that starts with START and a read address, with no pointer byte, begins at the pointer left by the previous transfer.
- R8: Addresses at NUM_CTRL+NUM_STAT and above read as FFh. Writes to status or unimplemented addresses change nothing and raise no strobe, but they are still ACKed and still advance the pointer.
- R9: A STOP at any point ends the transfer and returns the slave to idle. A partly received byte is discarded.
- R10: A STOP that falls in the same SCL high period as the START before it is ignored, and the transfer continues.
- R11: A NACK from the master after a read byte ends the read. SDA stays released until the next START.
- R12: Each written control register raises its own `wr_stb` bit for exactly one clock. At most one bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 2 | Strap code for the two low address bits |
| scl_i | input | 1 | Serial clock as seen at the pad |
| sda_i | input | 1 | Serial data as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| stat_in | input | NUM_STAT*8 | Status register values; register j in bits [8j+7:8j] |
| ctrl_q | output | NUM_CTRL*8 | Control register contents; register k in bits [8k+7:8k] |
| wr_stb | output | NUM_CTRL | One-cycle write pulse per control register |

## Verification
The bench targets these corner cases:
- **Pointer across STOP.** A design that clears the pointer on STOP would return register 0 instead of the resumed address.
- **Pointer wrap and the fill value.** A read that crosses FFh must come back to control register 0. Addresses past the status registers must return FFh, not an aliased register.
- **Aborted byte.** A STOP in the middle of a data byte must leave the target register untouched. A design that commits partial bytes would raise a stray strobe.
- **STOP in the START's high period.** If the slave honours this STOP, it drops to idle and never acknowledges the address that follows.
- **Wrong address, then master NACK.** In both cases the bench clocks the bus further. A slave that keeps driving would pull SDA low on a bus it no longer owns.

// File: rtl/i2c_slv_pkg.sv
`timescale 1ns/1ps
package i2c_slv_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PTR_W     = 8;
  localparam logic [7:0]  FILL_BYTE = 8'hFF;

  // Bus phase of the frame engine
  typedef enum logic [2:0] {
    PH_IDLE,  // not addressed, SDA released
    PH_RX,    // shifting in a byte from the master
    PH_ACK,   // slave holds SDA low for the ninth clock
    PH_TX,    // shifting out a read byte
    PH_MACK   // master acknowledge slot after a read byte
  } phase_e;

  // Meaning of the byte being received
  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } kind_e;

  // Slave address built from the fixed upper bits and the strap code
  function automatic logic [6:0] slave_addr(input logic [6:0] base, input logic [1:0] sel);
    return {base[6:2], sel};
  endfunction

  // Next pointer value, wrapping at the pointer width
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  localparam int DEPTH = STAGES + 1;

  logic [1:0] pin;
  logic [DEPTH-1:0] pipe [2];
  logic scl_d, sda_d;

  assign pin = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[l] <= '1;
      else        pipe[l] <= {pipe[l][DEPTH-2:0], pin[l]};
    end
  end

  assign scl_s = pipe[0][STAGES-1];
  assign scl_d = pipe[0][STAGES];
  assign sda_s = pipe[1][STAGES-1];
  assign sda_d = pipe[1][STAGES];

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_frame_ctl.sv
`timescale 1ns/1ps
module i2c_frame_ctl
  import i2c_slv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic [6:0]       my_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0] rd_addr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic             sda_oe,
  output logic             st_idle,
  output logic             start_hi
);
  phase_e ph;
  kind_e  kind;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [PTR_W-1:0]  ptr;
  logic              rd_mode;
  logic              m_nack;

  assign rd_addr = ptr;
  assign st_idle = (ph == PH_IDLE);
  assign sda_oe  = (ph == PH_ACK) | ((ph == PH_TX) & ~tx_sh[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      kind     <= BK_ADDR;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '1;
      ptr      <= '0;
      rd_mode  <= 1'b0;
      m_nack   <= 1'b1;
      start_hi <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev_start)      start_hi <= 1'b1;
      else if (scl_fall) start_hi <= 1'b0;

      if (ev_start) begin
        ph     <= PH_RX;
        kind   <= BK_ADDR;
        bitcnt <= '0;
      end else if (ev_stop && !start_hi) begin
        ph <= PH_IDLE;
      end else begin
        unique case (ph)
          PH_RX: begin
            if (scl_rise) begin
              rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              unique case (kind)
                BK_ADDR: begin
                  if (rx_sh[7:1] == my_addr) begin
                    rd_mode <= rx_sh[0];
                    ph      <= PH_ACK;
                  end else begin
                    ph <= PH_IDLE;
                  end
                end
                BK_PTR: begin
                  ptr <= rx_sh;
                  ph  <= PH_ACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= rx_sh;
                  ptr     <= ptr_next(ptr);
                  ph      <= PH_ACK;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              if (kind == BK_ADDR && rd_mode) begin
                ph    <= PH_TX;
                tx_sh <= rd_data;
              end else begin
                ph   <= PH_RX;
                kind <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                bitcnt <= '0;
                tx_sh  <= '1;
                ptr    <= ptr_next(ptr);
                ph     <= PH_MACK;
              end else begin
                bitcnt <= bitcnt + 4'd1;
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b1};
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              m_nack <= sda_s;
            end else if (scl_fall) begin
              if (m_nack) begin
                ph <= PH_IDLE;
              end else begin
                ph    <= PH_TX;
                tx_sh <= rd_data;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_bank.sv
`timescale 1ns/1ps
module i2c_reg_bank
  import i2c_slv_pkg::*;
#(
  parameter int NUM_CTRL = 4,
  parameter int NUM_STAT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [PTR_W-1:0]           rd_addr,
  output logic [BYTE_W-1:0]          rd_data,
  input  logic [NUM_STAT*BYTE_W-1:0] stat_in,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl_q,
  output logic [NUM_CTRL-1:0]        wr_stb
);
  logic [NUM_CTRL-1:0][BYTE_W-1:0] ctrl_r;
  logic [NUM_CTRL-1:0]             stb_r;

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_r[k] <= '0;
        stb_r[k]  <= 1'b0;
      end else begin
        stb_r[k] <= 1'b0;
        if (wr_en && wr_addr == PTR_W'(k)) begin
          ctrl_r[k] <= wr_data;
          stb_r[k]  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data = FILL_BYTE;
    for (int i = 0; i < NUM_CTRL; i++)
      if (rd_addr == PTR_W'(i)) rd_data = ctrl_r[i];
    for (int j = 0; j < NUM_STAT; j++)
      if (rd_addr == PTR_W'(NUM_CTRL + j)) rd_data = stat_in[j*BYTE_W +: BYTE_W];
  end

  assign ctrl_q = ctrl_r;
  assign wr_stb = stb_r;
endmodule

// File: rtl/i2c_regbank_slave.sv
`timescale 1ns/1ps
module i2c_regbank_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'h4C,
  parameter int         NUM_CTRL    = 4,
  parameter int         NUM_STAT    = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 addr_sel,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  input  logic [NUM_STAT*BYTE_W-1:0] stat_in,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl_q,
  output logic [NUM_CTRL-1:0]        wr_stb
);
  logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic st_idle, start_hi, wr_en;
  logic [PTR_W-1:0]  rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic [6:0]        my_addr;

  assign my_addr = slave_addr(BASE_ADDR, addr_sel);

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  i2c_frame_ctl frame_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .ev_start(ev_start), .ev_stop(ev_stop), .my_addr(my_addr),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_oe(sda_oe), .st_idle(st_idle), .start_hi(start_hi)
  );

  i2c_reg_bank #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .stat_in(stat_in), .ctrl_q(ctrl_q),
    .wr_stb(wr_stb)
  );
endmodule

// File: rtl/i2c_regbank_slave_chk.sv
`timescale 1ns/1ps
module i2c_regbank_slave_chk #(
  parameter int NUM_CTRL = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sda_oe,
  input logic                scl_s,
  input logic                ev_start,
  input logic                ev_stop,
  input logic                start_hi,
  input logic                st_idle,
  input logic [NUM_CTRL-1:0] wr_stb
);
  // R12: strobes never overlap
  a_r12_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  // R3 / R11: an idle slave never pulls SDA
  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe);

  // R9: an honoured STOP lands in idle
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !start_hi) |=> st_idle);

  // R10: a STOP in the START's high period leaves the frame open
  a_r10_stop_with_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && start_hi) |=> !st_idle);

  // R6: SDA drive moves only while SCL is low, unless a bus condition reset the frame
  a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_s || $past(ev_start) || $past(ev_stop)));
endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk #(.NUM_CTRL(NUM_CTRL)) chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .ev_start(ev_start),
  .ev_stop(ev_stop), .start_hi(start_hi), .st_idle(st_idle), .wr_stb(wr_stb)
);

// File: tb/i2c_regbank_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_regbank_slave_tb_top;
  localparam logic [6:0] BASE = 7'h4C;
  localparam int NC = 4;
  localparam int NS = 2;
  localparam int Q  = 6;
  localparam logic [NS*8-1:0] STAT_V = {8'hC3, 8'h3C};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr_sel = 2'd2;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NC*8-1:0] ctrl_q;
  logic [NC-1:0] wr_stb;

  int n_chk = 0;
  int n_fail = 0;
  int stb_cnt = 0;
  int oe_cnt = 0;
  int cyc = 0;

  logic [7:0] ctrl_m [NC];
  logic [7:0] wbuf [8];
  logic [7:0] ptr_m = 8'h00;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regbank_slave #(.BASE_ADDR(BASE), .NUM_CTRL(NC), .NUM_STAT(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .stat_in(STAT_V), .ctrl_q(ctrl_q), .wr_stb(wr_stb)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (|wr_stb) stb_cnt++;
    if (sda_oe) oe_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [7:0] addr_byte(input logic [1:0] sel, input bit rd);
    return {BASE[6:2], sel, rd};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    if (p < 8'(NC)) return ctrl_m[p[1:0]];
    if (p < 8'(NC + NS)) return STAT_V[(int'(p) - NC)*8 +: 8];
    return 8'hFF;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1; scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_rstart;
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(input bit last, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(last);
  endtask

  task automatic cmp_ctrl(input string req);
    for (int k = 0; k < NC; k++)
      chk(ctrl_q[k*8 +: 8] == ctrl_m[k], req, 32'(ctrl_q[k*8 +: 8]), 32'(ctrl_m[k]));
  endtask

  // pointer byte then n data bytes from wbuf; updates the model
  task automatic wr_frame(input logic [7:0] p, input int n, input string req);
    bit a;
    bus_start;
    put_byte(addr_byte(addr_sel, 1'b0), a); chk(a, req, 32'(a), 1);
    put_byte(p, a); chk(a, req, 32'(a), 1);
    ptr_m = p;
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], a); chk(a, req, 32'(a), 1);
      if (ptr_m < 8'(NC)) ctrl_m[ptr_m[1:0]] = wbuf[i];
      ptr_m = ptr_m + 8'd1;
    end
    bus_stop;
  endtask

  // optional pointer byte, then n read bytes compared with the model
  task automatic rd_frame(input bit with_ptr, input logic [7:0] p, input int n, input string req);
    bit a;
    logic [7:0] v;
    bus_start;
    if (with_ptr) begin
      put_byte(addr_byte(addr_sel, 1'b0), a); chk(a, req, 32'(a), 1);
      put_byte(p, a); chk(a, req, 32'(a), 1);
      ptr_m = p;
      bus_rstart;
    end
    put_byte(addr_byte(addr_sel, 1'b1), a); chk(a, req, 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i == n - 1, v);
      chk(v == exp_rd(ptr_m), req, 32'(v), 32'(exp_rd(ptr_m)));
      ptr_m = ptr_m + 8'd1;
    end
    bus_stop;
  endtask

  initial begin
    bit a;
    bit b;
    int s0;
    int o0;
    logic [7:0] v;
    void'($urandom(32'h5EED));
    for (int k = 0; k < NC; k++) ctrl_m[k] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1: reset state
    chk(sda_oe == 1'b0, "R1 sda", 32'(sda_oe), 0);
    chk(wr_stb == '0, "R1 strobe", 32'(wr_stb), 0);
    cmp_ctrl("R1 ctrl");

    // R2: every strap code, matching and non-matching address
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      tick(2);
      bus_start; put_byte(addr_byte(2'(s), 1'b0), a); chk(a, "R2 match", 32'(a), 1); bus_stop;
      bus_start; put_byte(addr_byte(2'(s) ^ 2'b01, 1'b0), a); chk(!a, "R2 mismatch", 32'(a), 0); bus_stop;
    end
    addr_sel = 2'd2;

    // R3: after a wrong address, a correct byte without START is ignored
    bus_start;
    put_byte(addr_byte(2'd0, 1'b0), a); chk(!a, "R3 nack", 32'(a), 0);
    o0 = oe_cnt;
    put_byte(addr_byte(addr_sel, 1'b0), a); chk(!a, "R3 no rematch", 32'(a), 0);
    chk(oe_cnt == o0, "R3 sda released", 32'(oe_cnt - o0), 0);
    bus_stop;

    // R4 / R12: single byte write
    s0 = stb_cnt;
    wbuf[0] = 8'hA5;
    wr_frame(8'h01, 1, "R4 single write");
    cmp_ctrl("R4 data");
    chk(stb_cnt - s0 == 1, "R12 one strobe", 32'(stb_cnt - s0), 1);

    // R5 / R12: burst write across all control registers
    s0 = stb_cnt;
    for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
    wr_frame(8'h00, 4, "R5 burst write");
    cmp_ctrl("R5 data");
    chk(stb_cnt - s0 == 4, "R12 burst strobes", 32'(stb_cnt - s0), 4);

    // R6: read everything implemented through a repeated START
    rd_frame(1'b1, 8'h00, 6, "R6 read map");

    // R7: pointer set, STOP, then read without pointer byte
    wr_frame(8'h02, 0, "R7 set ptr");
    rd_frame(1'b0, 8'h00, 2, "R7 resume");
    rd_frame(1'b0, 8'h00, 1, "R7 resume after read");

    // R8: writes to status and unimplemented addresses, reads past the map, wrap
    s0 = stb_cnt;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_frame(8'h04, 3, "R8 ignored writes");
    chk(stb_cnt == s0, "R8 no strobe", 32'(stb_cnt - s0), 0);
    rd_frame(1'b1, 8'h04, 4, "R8 status and fill");
    rd_frame(1'b1, 8'hFE, 3, "R5 R8 wrap");
    cmp_ctrl("R8 ctrl intact");

    // R9: STOP in the middle of a data byte
    s0 = stb_cnt;
    bus_start;
    put_byte(addr_byte(addr_sel, 1'b0), a); chk(a, "R9 addr", 32'(a), 1);
    put_byte(8'h01, a); chk(a, "R9 ptr", 32'(a), 1);
    ptr_m = 8'h01;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop;
    chk(stb_cnt == s0, "R9 no strobe", 32'(stb_cnt - s0), 0);
    cmp_ctrl("R9 ctrl intact");
    rd_frame(1'b0, 8'h00, 1, "R9 R7 read back");

    // R10: STOP inside the START's high period is ignored
    sda_m = 1; scl_m = 1; tick(Q);
    sda_m = 0; tick(Q);
    sda_m = 1; tick(Q);
    scl_m = 0; tick(Q);
    put_byte(addr_byte(addr_sel, 1'b0), a); chk(a, "R10 still addressed", 32'(a), 1);
    put_byte(8'h03, a); chk(a, "R10 ptr", 32'(a), 1);
    put_byte(8'h5A, a); chk(a, "R10 data", 32'(a), 1);
    ctrl_m[3] = 8'h5A; ptr_m = 8'h04;
    bus_stop;
    cmp_ctrl("R10 ctrl");

    // R11: master NACK ends the read, bus stays free
    bus_start;
    put_byte(addr_byte(addr_sel, 1'b0), a); chk(a, "R11 addr", 32'(a), 1);
    put_byte(8'h00, a); chk(a, "R11 ptr", 32'(a), 1);
    bus_rstart;
    put_byte(addr_byte(addr_sel, 1'b1), a); chk(a, "R11 raddr", 32'(a), 1);
    get_byte(1'b1, v); chk(v == ctrl_m[0], "R11 data", 32'(v), 32'(ctrl_m[0]));
    o0 = oe_cnt;
    for (int i = 0; i < 9; i++) get_bit(b);
    chk(oe_cnt == o0, "R11 released", 32'(oe_cnt - o0), 0);
    bus_stop;
    ptr_m = 8'h01;

    // Random write / read-back traffic
    for (int it = 0; it < 12; it++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom_range(0, 7));
      n = $urandom_range(1, 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_frame(p, n, "R4 R5 random write");
      rd_frame(1'b1, p, n, "R6 R8 random read");
    end
    cmp_ctrl("R4 final ctrl");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule